// File: doc/BRIEF.md
# Vectored External Interrupt Controller

This block sits between a set of peripherals and a single-interrupt-input processor core. Up to sixteen external request lines are masked by a per-source enable bit. The enable bits live in one memory-mapped register. The block also accepts a small number of internal causes, such as a timer expiry. From all unmasked requests it picks one winner and raises a single registered interrupt line to the core. With that line it gives the winner's source number and the byte address the core must jump to.

Internal causes each own a fixed 16-byte handler slot. The first slot starts at byte 16. External sources share one table of 4-byte jump entries, which follows directly after the internal slots, so source n lands on its own entry. When the core accepts the interrupt, it pulses `take` and offers its resume address. The block stores that address and enters the in-service state. While in service, no further interrupt is signalled. A return-from-interrupt pulse ends the service, and the stored address stays on `epc` so the core can resume from it.

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset, `irq`, `irq_num`, `vec_addr`, `in_service` and `epc` are all zero and every source enable bit is cleared.
- R2: A bus write whose address equals 0x8000_0000 loads data bit n into the enable bit of external source n. A write to any other address leaves the enables unchanged.
- R3: An external source can raise `irq` only while its request is high and its enable bit is set. Outputs are registered: inputs sampled at clock edge k are reflected on the outputs just after edge k.
- R4: When several enabled external sources are pending, the lowest-numbered one wins, and its number appears on `irq_num`.
- R5: Any pending internal cause has priority over all external sources, and among internal causes the lowest index wins. `irq_num` reads 0 while an internal cause is signalled.
- R6: The vector for internal cause i is the byte address 16 + 16*i.
- R7: The vector for external source n is the byte address 16 + 16*NUM_INT + 4*n, which is 64 + 4*n with three internal causes.
- R8: A `take` pulse sampled while `irq` is high sets `in_service` and copies `ret_pc` into `epc`. From that edge on, `irq` is low.
- R9: While `in_service` is high, `irq` stays low whatever the requests are (no nesting).
- R10: A `uret` pulse clears `in_service`. A pending request raises `irq` at the same edge. A `uret` while not in service changes nothing.
- R11: Whenever `irq` is low, `irq_num` and `vec_addr` read zero.
- R12: A `take` sampled while `irq` is low is ignored: `in_service` and `epc` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 16 | Level requests from external sources |
| int_req | input | 3 | Level requests from internal causes |
| bus_we | input | 1 | Register-bus write strobe |
| bus_addr | input | 32 | Register-bus write address |
| bus_wdata | input | 32 | Register-bus write data |
| take | input | 1 | Core accepts the signalled interrupt |
| uret | input | 1 | Core executes return-from-interrupt |
| ret_pc | input | 32 | Resume address offered with `take` |
| irq | output | 1 | Interrupt line to the core |
| irq_num | output | 4 | Winning external source number |
| vec_addr | output | 32 | Handler or jump-entry byte address |
| in_service | output | 1 | An interrupt is being served |
| epc | output | 32 | Saved resume address |

## Verification
The assertions assume that reset has been held for at least one edge, and that every input is stable around the sampling edge. The past-value checks on the enable mask and on internal requests depend on this. They do not assume that `take` and `uret` are exclusive or that they are single pulses. The design resolves their overlap itself, so the stimulus drives both freely in the random phase, including `take` while `irq` is low and `uret` outside service. The stimulus changes inputs one nanosecond after each rising edge. The bench compares outputs at the falling edge, so every sampled input has settled.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned MAX_IDW = 8;

  // Winner of an arbitration round.
  typedef struct packed {
    logic               valid;
    logic               is_ext;
    logic [MAX_IDW-1:0] idx;
  } irqc_pick_t;

  // Byte address of the handler slot owned by internal cause idx.
  function automatic logic [31:0] internal_vec(input logic [31:0] base,
                                               input logic [31:0] slot_bytes,
                                               input logic [31:0] idx);
    return base + slot_bytes * idx;
  endfunction

  // Byte address of the jump entry owned by external source idx.
  function automatic logic [31:0] external_vec(input logic [31:0] base,
                                               input logic [31:0] slot_bytes,
                                               input logic [31:0] n_int,
                                               input logic [31:0] jump_bytes,
                                               input logic [31:0] idx);
    return base + slot_bytes * n_int + jump_bytes * idx;
  endfunction

endpackage

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
  parameter int unsigned NSRC    = 16,
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter logic [AW-1:0] EN_ADDR = 32'h8000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [NSRC-1:0] en_q
);

  logic hit;
  assign hit = bus_we && (bus_addr == EN_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (hit) begin
      en_q <= bus_wdata[NSRC-1:0];
    end
  end

  AST_EN_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (bus_addr == EN_ADDR)) |=> $stable(en_q)); // R2

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned W   = 16,
  parameter int unsigned IDW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]   req,
  output logic           valid,
  output logic [IDW-1:0] idx
);

  // Scan from the top so the lowest set index is written last and wins.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IDW'(i);
      end
    end
  end

endmodule

// File: rtl/irqc_service.sv
module irqc_service #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          uret,
  input  logic          irq_live,
  input  logic [AW-1:0] ret_pc,
  output logic          svc_q,
  output logic          svc_d,
  output logic [AW-1:0] epc_q
);

  logic accept;
  assign accept = take && irq_live;

  always_comb begin
    svc_d = svc_q;
    if (accept) begin
      svc_d = 1'b1;
    end else if (uret) begin
      svc_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q <= 1'b0;
      epc_q <= '0;
    end else begin
      svc_q <= svc_d;
      if (accept) begin
        epc_q <= ret_pc;
      end
    end
  end

  AST_NO_NEST: assert property (@(posedge clk) disable iff (rst)
    svc_q |-> !irq_live); // R9

  AST_EPC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (take && irq_live) |=> (svc_q && epc_q == $past(ret_pc))); // R8

  AST_URET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (uret && !(take && irq_live)) |=> !svc_q); // R10

  AST_TAKE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (take && !irq_live && !uret) |=> ($stable(svc_q) && $stable(epc_q))); // R12

endmodule

// File: rtl/irqc_vector_gen.sv
module irqc_vector_gen
  import irqc_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned NUM_INT    = 3,
  parameter int unsigned VEC_BASE   = 16,
  parameter int unsigned SLOT_BYTES = 16,
  parameter int unsigned JUMP_BYTES = 4
) (
  input  irqc_pick_t    pick,
  output logic [AW-1:0] vec
);

  logic [31:0] full;

  always_comb begin
    if (!pick.valid) begin
      full = '0;
    end else if (pick.is_ext) begin
      full = external_vec(32'(VEC_BASE), 32'(SLOT_BYTES), 32'(NUM_INT),
                          32'(JUMP_BYTES), 32'(pick.idx));
    end else begin
      full = internal_vec(32'(VEC_BASE), 32'(SLOT_BYTES), 32'(pick.idx));
    end
  end

  assign vec = AW'(full);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC       = 16,
  parameter int unsigned NUM_INT    = 3,
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter logic [31:0] EN_ADDR    = 32'h8000_0000,
  parameter int unsigned VEC_BASE   = 16,
  parameter int unsigned SLOT_BYTES = 16,
  parameter int unsigned JUMP_BYTES = 4,
  localparam int unsigned IDW       = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int unsigned IIDW      = (NUM_INT > 1) ? $clog2(NUM_INT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    src_req,
  input  logic [NUM_INT-1:0] int_req,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               take,
  input  logic               uret,
  input  logic [AW-1:0]      ret_pc,
  output logic               irq,
  output logic [IDW-1:0]     irq_num,
  output logic [AW-1:0]      vec_addr,
  output logic               in_service,
  output logic [AW-1:0]      epc
);

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] masked;
  logic            ext_valid;
  logic [IDW-1:0]  ext_idx;
  logic            int_valid;
  logic [IIDW-1:0] int_idx;
  logic            svc_q;
  logic            svc_d;
  irqc_pick_t      pick;
  logic [AW-1:0]   vec_d;
  logic            irq_q;
  logic            ext_q;
  logic [IDW-1:0]  num_q;
  logic [AW-1:0]   vec_q;

  irqc_enable_reg #(
    .NSRC(NSRC), .AW(AW), .DW(DW), .EN_ADDR(AW'(EN_ADDR))
  ) u_en (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_q(en_q)
  );

  assign masked = src_req & en_q;

  irqc_prio #(.W(NSRC), .IDW(IDW)) u_ext_prio (
    .req(masked), .valid(ext_valid), .idx(ext_idx)
  );

  irqc_prio #(.W(NUM_INT), .IDW(IIDW)) u_int_prio (
    .req(int_req), .valid(int_valid), .idx(int_idx)
  );

  irqc_service #(.AW(AW)) u_svc (
    .clk(clk), .rst(rst), .take(take), .uret(uret), .irq_live(irq_q),
    .ret_pc(ret_pc), .svc_q(svc_q), .svc_d(svc_d), .epc_q(epc)
  );

  // Internal causes outrank every external source.
  always_comb begin
    pick = '0;
    if (!svc_d) begin
      if (int_valid) begin
        pick.valid  = 1'b1;
        pick.is_ext = 1'b0;
        pick.idx    = MAX_IDW'(int_idx);
      end else if (ext_valid) begin
        pick.valid  = 1'b1;
        pick.is_ext = 1'b1;
        pick.idx    = MAX_IDW'(ext_idx);
      end
    end
  end

  irqc_vector_gen #(
    .AW(AW), .NUM_INT(NUM_INT), .VEC_BASE(VEC_BASE),
    .SLOT_BYTES(SLOT_BYTES), .JUMP_BYTES(JUMP_BYTES)
  ) u_vec (
    .pick(pick), .vec(vec_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      ext_q <= 1'b0;
      num_q <= '0;
      vec_q <= '0;
    end else begin
      irq_q <= pick.valid;
      ext_q <= pick.valid && pick.is_ext;
      num_q <= (pick.valid && pick.is_ext) ? IDW'(pick.idx) : '0;
      vec_q <= vec_d;
    end
  end

  assign irq        = irq_q;
  assign irq_num    = num_q;
  assign vec_addr   = vec_q;
  assign in_service = svc_q;

  AST_EXT_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (irq_q && ext_q) |-> (|(($past(masked) >> irq_num) & NSRC'(1)))); // R3

  AST_INT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (irq_q && ext_q) |-> ($past(int_req) == '0)); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_q |-> (irq_num == '0 && vec_addr == '0)); // R11

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (vec_addr >= AW'(VEC_BASE) && vec_addr[1:0] == 2'b00)); // R6

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_req = '0;
  logic [2:0]  int_req = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        take = 1'b0;
  logic        uret = 1'b0;
  logic [31:0] ret_pc = '0;
  logic        irq;
  logic [3:0]  irq_num;
  logic [31:0] vec_addr;
  logic        in_service;
  logic [31:0] epc;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst(rst), .src_req(src_req), .int_req(int_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .take(take), .uret(uret), .ret_pc(ret_pc), .irq(irq),
    .irq_num(irq_num), .vec_addr(vec_addr), .in_service(in_service),
    .epc(epc)
  );

  // Behavioural reference state.
  bit [15:0] m_en;
  bit        m_svc, m_irq;
  int        m_num;
  bit [31:0] m_vec, m_epc;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_svc = 0; m_irq = 0; m_num = 0; m_vec = 0; m_epc = 0;
    end else begin
      bit nsvc;
      bit [15:0] pend;
      bit hit;
      int n;
      bit [31:0] v;
      nsvc = m_svc;
      if (take && m_irq) begin
        nsvc = 1;
        m_epc = ret_pc;
      end else if (uret) begin
        nsvc = 0;
      end
      pend = src_req & m_en;
      hit = 0; n = 0; v = 0;
      if (int_req != 0) begin
        for (int i = 2; i >= 0; i--) if (int_req[i]) v = 16 + 16 * i;
        hit = 1;
      end else if (pend != 0) begin
        for (int i = 15; i >= 0; i--) if (pend[i]) n = i;
        v = 64 + 4 * n;
        hit = 1;
      end
      m_irq = hit && !nsvc;
      m_num = m_irq ? n : 0;
      m_vec = m_irq ? v : 0;
      m_svc = nsvc;
      if (bus_we && bus_addr == 32'h8000_0000) m_en = bus_wdata[15:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Clock-by-clock comparison against the reference.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R4 irq_num", {28'd0, irq_num}, 32'(m_num));
      chk("R7 vec_addr", vec_addr, m_vec);
      chk("R8 in_service", {31'd0, in_service}, {31'd0, m_svc});
      chk("R8 epc", epc, m_epc);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_we = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 vec", vec_addr, 32'd0);
    chk("R1 svc", {31'd0, in_service}, 32'd0);
    chk("R1 epc", epc, 32'd0);

    // R2: wrong address ignored
    src_req = 16'h0020;
    wr(32'h8000_0004, 32'hFFFF);
    step(3);
    chk("R2 ignored", {31'd0, irq}, 32'd0);

    // R3/R7: enabled single source
    wr(32'h8000_0000, 32'h0020);
    step(2);
    chk("R3 irq", {31'd0, irq}, 32'd1);
    chk("R7 num5", {28'd0, irq_num}, 32'd5);
    chk("R7 vec5", vec_addr, 32'd84);

    // R4: lowest pending wins
    src_req = 16'h0208;
    wr(32'h8000_0000, 32'hFFFF);
    step(2);
    chk("R4 num", {28'd0, irq_num}, 32'd3);
    chk("R4 vec", vec_addr, 32'd76);

    // R3: masked source stays silent
    src_req = 16'h0040;
    wr(32'h8000_0000, 32'hFFBF);
    step(2);
    chk("R3 masked", {31'd0, irq}, 32'd0);

    // R5/R6: internal causes outrank externals
    src_req = 16'h0208;
    int_req = 3'b110;
    step(2);
    chk("R5 num", {28'd0, irq_num}, 32'd0);
    chk("R6 vec", vec_addr, 32'd32);
    int_req = 3'b000;
    step(2);

    // R8: take
    take = 1'b1; ret_pc = 32'h0000_1234;
    step(1);
    take = 1'b0;
    chk("R8 svc", {31'd0, in_service}, 32'd1);
    chk("R8 irq", {31'd0, irq}, 32'd0);
    chk("R8 epc", epc, 32'h0000_1234);

    // R9: no nesting
    src_req = 16'hFFFF; int_req = 3'b001;
    step(5);
    chk("R9 irq", {31'd0, irq}, 32'd0);
    int_req = 3'b000; src_req = 16'h0208;

    // R12: take while irq low
    take = 1'b1; ret_pc = 32'hDEAD_0000;
    step(1);
    take = 1'b0;
    chk("R12 epc", epc, 32'h0000_1234);
    chk("R12 svc", {31'd0, in_service}, 32'd1);

    // R10: uret ends service, pending request returns at once
    uret = 1'b1;
    step(1);
    uret = 1'b0;
    chk("R10 svc", {31'd0, in_service}, 32'd0);
    chk("R10 irq", {31'd0, irq}, 32'd1);
    chk("R10 num", {28'd0, irq_num}, 32'd3);

    // R11: idle outputs read zero
    src_req = 16'h0000;
    step(1);
    chk("R11 num", {28'd0, irq_num}, 32'd0);
    chk("R11 vec", vec_addr, 32'd0);
    uret = 1'b1;
    step(1);
    uret = 1'b0;
    chk("R10 idle uret", {31'd0, in_service}, 32'd0);

    // Random phase, checked by the reference every clock.
    for (int k = 0; k < 4000; k++) begin
      src_req = 16'($urandom) & 16'($urandom);
      int_req = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
      take    = (($urandom % 4) == 0);
      uret    = (($urandom % 6) == 0);
      ret_pc  = $urandom;
      bus_we  = (($urandom % 10) == 0);
      bus_addr  = (($urandom % 2) == 0) ? 32'h8000_0000 : 32'h8100_0000;
      bus_wdata = $urandom;
      step(1);
    end
    take = 1'b0; uret = 1'b0; bus_we = 1'b0;
    step(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule